// File: doc/BRIEF.md
# Chained Serial Configuration Register

This block is the serial front end of one node in a string of LED driver nodes. A host streams 31-bit frames over a serial clock and data pair; each node shifts the stream through its own register and hands the oldest bit to the next node. When the host pulses the latch strobe, every node copies its frame into holding registers. The top bit of the frame picks the destination: either three 10-bit brightness words, or three 7-bit current-scale words together with a 2-bit clock-divider code.

The serial clock, data and latch inputs are sampled with a faster system clock through two-stage synchronizers. Edge detectors then drive all state changes in that one domain. The serial output moves on the falling edge of the serial clock, half a bit after the register shifts on the rising edge. This keeps a long chain free of races. An undervoltage flag, which is synchronous to the system clock, freezes shifting and holds every register at zero. The node therefore comes back from undervoltage in a cleared state.

Top module: `serial_cfg_node`

## Requirements
- R1: On each rising serial-clock edge the register shifts toward its MSB and takes the serial data bit into bit 0. The first bit sent ends in bit 30. When more than 31 bits are sent, only the last 31 count.
- R2: The serial output takes the value of register bit 30 on the falling serial-clock edge only. A rising edge leaves it unchanged.
- R3: Holding registers change only on a rising edge of the latch strobe, or through undervoltage.
- R4: A latch with bit 30 = 0 loads the brightness words: channel 0 from bits 9:0, channel 1 from bits 19:10 and channel 2 from bits 29:20.
- R5: A latch with bit 30 = 1 loads the scale words and the divider code: channel 0 scale from bits 6:0, divider from bits 8:7, channel 1 scale from bits 16:10 and channel 2 scale from bits 26:20.
- R6: A latch leaves the bank that bit 30 does not select unchanged.
- R7: While undervoltage is high, the register does not shift and latches are ignored. The shift register, the serial output and all holding registers read zero while the flag is high and after it falls.
- R8: After reset, all outputs are zero.
- R9: Frame bits 9, 17 to 19 and 27 to 29 have no effect in a scale/divider frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the upstream node |
| sdi_i | input | 1 | Serial data from the upstream node |
| latch_i | input | 1 | Latch strobe; a rising edge transfers the frame |
| uv_i | input | 1 | Undervoltage flag, synchronous to clk_i |
| sdo_o | output | 1 | Serial data to the downstream node |
| bright_o | output | 30 | Brightness words, channel n at bits 10n+9:10n |
| scale_o | output | 21 | Current-scale words, channel n at bits 7n+6:7n |
| div_o | output | 2 | Clock-divider code |

## Verification
Some rules are checked on every cycle. The serial output may move only after a falling serial-clock edge. Each bank may change only after a latch whose address bit selects it, or through undervoltage. Every output must be zero while undervoltage is high. Other behaviour only the bench scenarios can show: the correct field mapping of each frame type, MSB-first ordering, and that overlong streams keep only the newest 31 bits. The scenarios also show that padding and test bits are ignored, that clocking during undervoltage shifts nothing, and that a latch taken after recovery sees a cleared frame.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  parameter int N_CH        = 3;
  parameter int BRIGHT_W    = 10;
  parameter int SCALE_W     = 7;
  parameter int DIV_W       = 2;
  parameter int SYNC_STAGES = 2;

  localparam int FRAME_W  = N_CH * BRIGHT_W + 1;
  localparam int ADDR_BIT = FRAME_W - 1;
  localparam int DIV_LSB  = SCALE_W;

  typedef logic [N_CH-1:0][BRIGHT_W-1:0] bright_t;
  typedef logic [N_CH-1:0][SCALE_W-1:0]  scale_t;
  typedef logic [DIV_W-1:0]              div_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         fall_i,
  input  logic         sdi_i,
  output logic [W-1:0] sr_o,
  output logic         sdo_o
);
  logic [W-1:0] sr_q;
  logic         sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clr_i)   sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], sdi_i};
  end

  // downstream bit re-timed to the opposite serial edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sdo_q <= 1'b0;
    else if (clr_i)  sdo_q <= 1'b0;
    else if (fall_i) sdo_q <= sr_q[W-1];
  end

  assign sr_o  = sr_q;
  assign sdo_o = sdo_q;
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import serial_cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output bright_t            bright_o,
  output scale_t             scale_o,
  output div_t               div_o
);
  logic    sel_scale;
  bright_t bright_q;
  scale_t  scale_q;
  div_t    div_q;

  assign sel_scale = frame_i[ADDR_BIT];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    bright_q[c] <= '0;
      else if (clr_i)                 bright_q[c] <= '0;
      else if (load_i && !sel_scale)  bright_q[c] <= frame_i[c*BRIGHT_W +: BRIGHT_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    scale_q[c] <= '0;
      else if (clr_i)                 scale_q[c] <= '0;
      else if (load_i && sel_scale)   scale_q[c] <= frame_i[c*BRIGHT_W +: SCALE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  div_q <= '0;
    else if (clr_i)               div_q <= '0;
    else if (load_i && sel_scale) div_q <= frame_i[DIV_LSB +: DIV_W];
  end

  assign bright_o = bright_q;
  assign scale_o  = scale_q;
  assign div_o    = div_q;
endmodule

// File: rtl/serial_cfg_node.sv
module serial_cfg_node
  import serial_cfg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sclk_i,
  input  logic    sdi_i,
  input  logic    latch_i,
  input  logic    uv_i,
  output logic    sdo_o,
  output bright_t bright_o,
  output scale_t  scale_o,
  output div_t    div_o
);
  logic [2:0]         sync_q;
  logic [1:0]         prev_q;
  logic               sclk_s, sdi_s, latch_s;
  logic               sclk_rise, sclk_fall, latch_rise;
  logic [FRAME_W-1:0] sr_q;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({latch_i, sdi_i, sclk_i}),
    .q_o    (sync_q)
  );

  assign {latch_s, sdi_s, sclk_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= {latch_s, sclk_s};
  end

  assign sclk_rise  =  sclk_s  & ~prev_q[0];
  assign sclk_fall  = ~sclk_s  &  prev_q[0];
  assign latch_rise =  latch_s & ~prev_q[1];

  cfg_shift #(.W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (uv_i),
    .shift_i (sclk_rise & ~uv_i),
    .fall_i  (sclk_fall),
    .sdi_i   (sdi_s),
    .sr_o    (sr_q),
    .sdo_o   (sdo_o)
  );

  cfg_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (uv_i),
    .load_i   (latch_rise & ~uv_i),
    .frame_i  (sr_q),
    .bright_o (bright_o),
    .scale_o  (scale_o),
    .div_o    (div_o)
  );
endmodule

// File: rtl/serial_cfg_node_chk.sv
module serial_cfg_node_chk
  import serial_cfg_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    uv_i,
  input logic    sclk_fall,
  input logic    latch_rise,
  input logic    addr_bit,
  input logic    sdo_o,
  input bright_t bright_o,
  input scale_t  scale_o,
  input div_t    div_o
);
  p_sdo_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> ($past(sclk_fall) || $past(uv_i)));

  p_bright_update_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bright_o) |-> ($past(uv_i) || ($past(latch_rise) && !$past(addr_bit))));

  p_scale_update_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(scale_o) || !$stable(div_o)) |->
      ($past(uv_i) || ($past(latch_rise) && $past(addr_bit))));

  p_uv_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(uv_i) |-> (bright_o == '0 && scale_o == '0 && div_o == '0 && !sdo_o));

  p_reset_zero_r8: assert property (@(posedge clk_i)
    !rst_ni |-> (bright_o == '0 && scale_o == '0 && div_o == '0 && !sdo_o));
endmodule

bind serial_cfg_node serial_cfg_node_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .uv_i       (uv_i),
  .sclk_fall  (sclk_fall),
  .latch_rise (latch_rise),
  .addr_bit   (sr_q[serial_cfg_pkg::ADDR_BIT]),
  .sdo_o      (sdo_o),
  .bright_o   (bright_o),
  .scale_o    (scale_o),
  .div_o      (div_o)
);

// File: tb/serial_cfg_node_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_node_tb_top;
  import serial_cfg_pkg::*;

  logic    clk = 1'b0;
  logic    rst_n = 1'b0;
  logic    sclk = 1'b0, sdi = 1'b0, latch = 1'b0, uv = 1'b0;
  logic    sdo;
  bright_t bright;
  scale_t  scale;
  div_t    div;

  always #2.5 clk = ~clk;

  serial_cfg_node dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi),
    .latch_i(latch), .uv_i(uv), .sdo_o(sdo),
    .bright_o(bright), .scale_o(scale), .div_o(div)
  );

  typedef struct {
    bright_t b;
    scale_t  s;
    div_t    d;
    string   req;
  } exp_t;

  exp_t    sb_q[$];
  event    ev_chk;
  int      n_run = 0, n_fail = 0;
  logic [30:0] mdl_sr = '0;
  logic        mdl_sdo = 1'b0;
  bright_t     mdl_b = '0;
  scale_t      mdl_s = '0;
  div_t        mdl_d = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_exp(input string req);
    exp_t e;
    e.b = mdl_b; e.s = mdl_s; e.d = mdl_d; e.req = req;
    sb_q.push_back(e);
    ->ev_chk;
    @(negedge clk);
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(ev_chk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        for (int c = 0; c < N_CH; c++) begin
          chk({e.req, " bright"}, 32'(bright[c]), 32'(e.b[c]));
          chk({e.req, " scale"},  32'(scale[c]),  32'(e.s[c]));
        end
        chk({e.req, " div"}, 32'(div), 32'(e.d));
      end
    end
  end

  task automatic sclk_bit(input logic b);
    @(negedge clk); sdi = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    if (!uv) mdl_sr = {mdl_sr[29:0], b};
    repeat (6) @(negedge clk);
    chk("R2 sdo held on rise", 32'(sdo), 32'(mdl_sdo));
    sclk = 1'b0;
    mdl_sdo = uv ? 1'b0 : mdl_sr[30];
    repeat (6) @(negedge clk);
    chk(uv ? "R7 sdo under uv" : "R2 sdo on fall", 32'(sdo), 32'(mdl_sdo));
  endtask

  task automatic send_frame(input logic [30:0] w);
    for (int i = 30; i >= 0; i--) sclk_bit(w[i]);
  endtask

  task automatic do_latch(input string req);
    @(negedge clk); latch = 1'b1;
    repeat (6) @(negedge clk);
    latch = 1'b0;
    if (!uv) begin
      if (mdl_sr[30]) begin
        for (int c = 0; c < N_CH; c++) mdl_s[c] = mdl_sr[c*10 +: 7];
        mdl_d = mdl_sr[8:7];
      end else begin
        for (int c = 0; c < N_CH; c++) mdl_b[c] = mdl_sr[c*10 +: 10];
      end
    end
    repeat (6) @(negedge clk);
    push_exp(req);
  endtask

  task automatic set_uv(input logic v);
    @(negedge clk); uv = v;
    if (v) begin
      mdl_sr = '0; mdl_sdo = 1'b0; mdl_b = '0; mdl_s = '0; mdl_d = '0;
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [30:0] scale_frame(input logic [6:0] s0, input logic [6:0] s1,
                                              input logic [6:0] s2, input logic [1:0] d,
                                              input logic [5:0] junk);
    logic [30:0] w;
    w = '0;
    w[30] = 1'b1;
    w[6:0] = s0; w[8:7] = d; w[16:10] = s1; w[26:20] = s2;
    w[9] = junk[0]; w[19:17] = junk[3:1]; w[27] = junk[4]; w[29:28] = {2{junk[5]}};
    return w;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    chk("R8 sdo reset", 32'(sdo), 32'd0);
    push_exp("R8 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: brightness frame
    send_frame({1'b0, 10'h155, 10'h000, 10'h3FF});
    do_latch("R4");

    // R5/R9/R6: scale frame with padding and test bits set; brightness must hold
    send_frame(scale_frame(7'h7F, 7'h00, 7'h55, 2'b10, 6'h3F));
    do_latch("R5 R9 R6");

    // R6: brightness frame leaves scale/divider untouched
    send_frame({1'b0, 10'h3FE, 10'h2AA, 10'h001});
    do_latch("R6 R4");

    // R1: overlong stream, only the last 31 bits count
    sclk_bit(1'b1); sclk_bit(1'b0); sclk_bit(1'b1); sclk_bit(1'b1);
    send_frame(scale_frame(7'h12, 7'h34, 7'h56, 2'b01, 6'h00));
    do_latch("R1");

    // R7: pending frame lost, no shifting or latching under uv
    send_frame({1'b0, 10'h3FF, 10'h3FF, 10'h3FF});
    set_uv(1'b1);
    push_exp("R7 cleared");
    for (int i = 0; i < 5; i++) sclk_bit(1'b1);
    do_latch("R7 latch ignored");
    set_uv(1'b0);
    do_latch("R7 recovery");

    // R3: resume normal operation, no latch means no update
    send_frame({1'b0, 10'h0F0, 10'h00F, 10'h3C3});
    push_exp("R3 before latch");
    do_latch("R3 R4");

    repeat (10) @(negedge clk);
    chk("R3 scoreboard drained", 32'(sb_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule